// File: doc/BRIEF.md
# UART Host Register Bank

This block is the host-facing register file of a 16550-style serial port that also carries extended register pages. The host presents a 3-bit offset with separate read and write strobes. Each access goes to the transmit or receive data path, the two baud divisor bytes, or a configuration or status register. Which register answers at a given offset depends on the divisor-access bit and the page state held in the line-control register, and on two enable bits in an additional-control register.

Configuration leaves the block as steady outputs for a UART core: the 16-bit divisor, the frame format fields, the interrupt mask and the modem control lines. Live status, receive data, interrupt identification and indexed-register read data come in from that core. Transmit loads, receive pops, FIFO-control writes and indexed writes are signalled by single-cycle strobes, and the consumer takes the byte from `wdata`.

A read gives its value on `rdata` in the same cycle as `rd_en` and is zero when no read is in progress. A read that clears state clears it at the clock edge that ends the read. The additional-control register is reached at offset 2 while the enhanced page is open.

Top module: `uart_hostregs`

## Requirements
- R1: While the divisor-access bit is 0, a write at offset 0 pulses `tx_load` in that cycle, and a read at offset 0 returns `rx_data` and pulses `rx_pop`.
- R2: While the divisor-access bit is 1, offsets 0 and 1 read and write the low and high divisor bytes (`divisor[7:0]`, `divisor[15:8]`). No `tx_load` or `rx_pop` occurs, and the interrupt mask is untouched. Outside such writes `divisor` holds its value.
- R3: Outside the enhanced page, a write at offset 2 pulses `fcr_wr`, and a read at offset 2 returns `isr_in`.
- R4: Writing 0xBF at offset 3 opens the enhanced page and sets the divisor-access bit. The stored format bits 6:0 are kept, and line control then reads back as those bits with bit 7 set.
- R5: Writing any other value at offset 3 closes the enhanced page. Bit 7 of that value becomes the divisor-access bit and bits 6:0 become the stored format.
- R6: `lcr_fmt` carries stored line-control bits 6:0 in place: bit 6 transmit break, bit 5 forced parity, bit 4 even/odd select, bit 3 parity enable, bit 2 stop-bit count, bits 1:0 data length.
- R7: In the enhanced page, offset 2 reads and writes the additional-control register. While its bit 7 is 0, interrupt-mask bits 7:4 and modem-control bits 7:5 read back as zero, reach `ier_mask` and `mcr_out` as zero, and are written as zero. Modem-control bits 4:0 are loopback, OUT2, OUT1, RTS, DTR, and the register sits at offset 4.
- R8: While additional-control bit 6 is 1 (enhanced page closed), a write at offset 5 pulses `idx_wr`, and a read at offset 5 returns `idx_rdata` without clearing line status. `idx_addr` always equals the scratch register.
- R9: Line status at offset 5 reads as {error, tx_empty, thr_empty, break, framing, parity, overrun, rx_ready}. The four event bits latch `ev_brk`, `ev_frm`, `ev_par` and `ev_ovr`, and bit 7 latches any of break, framing or parity. All five clear on a status read, except that an event arriving in the read cycle stays set.
- R10: Modem status at offset 6 reads as {modem_in[3:0], delta DCD, RI trailing edge, delta DSR, delta CTS}, where `modem_in` is {DCD, RI, DSR, CTS}. A delta bit latches any change of its line, except the RI bit, which latches only a 1-to-0 change. Deltas clear on a read of this register, and a change arriving in the read cycle stays set.
- R11: Outside the enhanced page, offset 7 is a read/write scratch byte.
- R12: After reset, line control, divisor, interrupt mask, modem control, additional control, scratch, latched line-status bits and modem deltas are all zero, with the divisor hidden and the enhanced page closed.
- R13: While the enhanced page is open, offsets 4 to 7 read as zero, writes there change nothing, and reads there clear no status.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| addr | input | 3 | Register offset |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data, zero when no read is in progress |
| tx_load | output | 1 | Transmit byte load strobe |
| rx_pop | output | 1 | Receive byte consumed strobe |
| fcr_wr | output | 1 | FIFO-control write strobe |
| idx_wr | output | 1 | Indexed-register write strobe |
| idx_addr | output | 8 | Indexed-register offset (scratch value) |
| rx_data | input | 8 | Received byte from core |
| isr_in | input | 8 | Interrupt status from core |
| idx_rdata | input | 8 | Indexed-register read data |
| rx_ready | input | 1 | Receive data available |
| thr_empty | input | 1 | Transmit holding empty |
| tx_empty | input | 1 | Transmitter fully idle |
| ev_ovr | input | 1 | Overrun event pulse |
| ev_par | input | 1 | Parity error event pulse |
| ev_frm | input | 1 | Framing error event pulse |
| ev_brk | input | 1 | Break received event pulse |
| modem_in | input | 4 | Modem inputs {DCD, RI, DSR, CTS} |
| divisor | output | 16 | Baud divisor |
| lcr_fmt | output | 7 | Frame format and break control |
| ier_mask | output | 8 | Interrupt mask |
| mcr_out | output | 8 | Modem control |

## Verification
Directed sequences move through the page states in order: legacy, divisor-visible, enhanced, and back out with the extended enables on and off. Each offset is read in every state, so a wrong page decode shows up as the wrong register answering. Status is driven with events on their own, events landing in the same cycle as a clearing read, and events during reads that must not clear (indexed access, enhanced page). This separates read-to-clear ordering faults from decode faults. The modem lines are toggled in both directions, so that the RI trailing-edge rule can be told apart from a plain change detector. A long pseudo-random stretch of mixed accesses, including the 0xBF key, is compared every cycle against the bench model.

// File: rtl/uart_hostregs_pkg.sv
// Shared constants and types of the UART host register bank.
// Assumes an 8-bit register space with 8 offsets.
package uart_hostregs_pkg;
    localparam int HR_AW = 3;
    localparam int HR_DW = 8;

    localparam logic [HR_AW-1:0] OFS_DATA = 3'd0;
    localparam logic [HR_AW-1:0] OFS_IER  = 3'd1;
    localparam logic [HR_AW-1:0] OFS_FIFO = 3'd2;
    localparam logic [HR_AW-1:0] OFS_LCR  = 3'd3;
    localparam logic [HR_AW-1:0] OFS_MCR  = 3'd4;
    localparam logic [HR_AW-1:0] OFS_LSR  = 3'd5;
    localparam logic [HR_AW-1:0] OFS_MSR  = 3'd6;

    localparam logic [HR_DW-1:0] LCR_ENH_KEY   = 8'hBF;
    localparam logic [HR_DW-1:0] IER_BASE_MASK = 8'h0F;
    localparam logic [HR_DW-1:0] MCR_BASE_MASK = 8'h1F;
    localparam int               RI_BIT        = 2;

    // One select line per register that can answer an access.
    typedef struct packed {
        logic data;
        logic dll;
        logic dlm;
        logic ier;
        logic fifo;
        logic acr;
        logic lcr;
        logic mcr;
        logic lsr;
        logic idx;
        logic msr;
        logic spr;
    } hr_sel_t;
endpackage

// File: rtl/hr_decode.sv
// Page-aware offset decoder. Exactly one select is raised for an offset
// in the current page state, or none if the page leaves it unimplemented.
// Assumes dlab is already 1 whenever the enhanced page is open.
module hr_decode
    import uart_hostregs_pkg::*;
(
    input  logic [HR_AW-1:0] addr,
    input  logic             dlab,
    input  logic             enh,
    input  logic             icr_on,
    output hr_sel_t          sel
);
    // Map the offset onto a register, given divisor access and page state.
    always_comb begin
        sel = '0;
        case (addr)
            OFS_DATA: if (dlab) sel.dll = 1'b1; else sel.data = 1'b1;
            OFS_IER:  if (dlab) sel.dlm = 1'b1; else sel.ier  = 1'b1;
            OFS_FIFO: if (enh)  sel.acr = 1'b1; else sel.fifo = 1'b1;
            OFS_LCR:  sel.lcr = 1'b1;
            OFS_MCR:  sel.mcr = !enh;
            OFS_LSR: begin
                sel.idx = !enh && icr_on;
                sel.lsr = !enh && !icr_on;
            end
            OFS_MSR:  sel.msr = !enh;
            default:  sel.spr = !enh;
        endcase
    end
endmodule

// File: rtl/hr_ctrl.sv
// Configuration registers: line control with the enhanced-page key,
// divisor bytes, interrupt mask, modem control, additional control, scratch.
// Assumes at most one select is high per cycle.
module hr_ctrl
    import uart_hostregs_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en,
    input  logic [HR_DW-1:0]   wdata,
    input  logic               sel_lcr,
    input  logic               sel_dll,
    input  logic               sel_dlm,
    input  logic               sel_ier,
    input  logic               sel_mcr,
    input  logic               sel_acr,
    input  logic               sel_spr,
    output logic               dlab,
    output logic               enh,
    output logic [HR_DW-2:0]   lcr_fmt,
    output logic [2*HR_DW-1:0] divisor,
    output logic [HR_DW-1:0]   ier_q,
    output logic [HR_DW-1:0]   mcr_q,
    output logic [HR_DW-1:0]   acr_q,
    output logic [HR_DW-1:0]   spr_q
);
    logic [HR_DW-1:0] ext_keep_ier;
    logic [HR_DW-1:0] ext_keep_mcr;

    assign ext_keep_ier = acr_q[HR_DW-1] ? '1 : IER_BASE_MASK;
    assign ext_keep_mcr = acr_q[HR_DW-1] ? '1 : MCR_BASE_MASK;

    // Line control: the key opens the page and keeps the format bits.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dlab    <= 1'b0;
            enh     <= 1'b0;
            lcr_fmt <= '0;
        end else if (wr_en && sel_lcr) begin
            if (wdata == LCR_ENH_KEY) begin
                dlab <= 1'b1;
                enh  <= 1'b1;
            end else begin
                dlab    <= wdata[HR_DW-1];
                enh     <= 1'b0;
                lcr_fmt <= wdata[HR_DW-2:0];
            end
        end
    end

    // Divisor bytes, reachable only while divisor access is on.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            divisor <= '0;
        end else begin
            if (wr_en && sel_dll) divisor[HR_DW-1:0]       <= wdata;
            if (wr_en && sel_dlm) divisor[2*HR_DW-1:HR_DW] <= wdata;
        end
    end

    // Interrupt mask and modem control, upper fields gated by the extended enable.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ier_q <= '0;
            mcr_q <= '0;
        end else begin
            if (wr_en && sel_ier) ier_q <= wdata & ext_keep_ier;
            if (wr_en && sel_mcr) mcr_q <= wdata & ext_keep_mcr;
        end
    end

    // Additional control and scratch byte.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acr_q <= '0;
            spr_q <= '0;
        end else begin
            if (wr_en && sel_acr) acr_q <= wdata;
            if (wr_en && sel_spr) spr_q <= wdata;
        end
    end

    // R4: the key write keeps the frame format and opens the page.
    p_key_keeps_fmt_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && sel_lcr && wdata == LCR_ENH_KEY) |=>
            (enh && dlab && lcr_fmt == $past(lcr_fmt)));

    // R5: a plain line-control write closes the page and lands verbatim.
    p_plain_lcr_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && sel_lcr && wdata != LCR_ENH_KEY) |=>
            (!enh && {dlab, lcr_fmt} == $past(wdata)));

    // R2: the divisor moves only through its own selects.
    p_divisor_stable_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_en && (sel_dll || sel_dlm)) |=> $stable(divisor));

    // R12: leaving reset, the divisor is hidden and the page is closed.
    p_reset_closed_r12: assert property (@(posedge clk)
        $rose(rst_n) |-> (!dlab && !enh && lcr_fmt == '0));
endmodule

// File: rtl/hr_status.sv
// Line and modem status assembly with latched event bits that clear on
// read. An event arriving in the clearing cycle survives the clear.
// Assumes event inputs are single-cycle pulses from the UART core.
module hr_status
    import uart_hostregs_pkg::*;
#(
    parameter int N_MODEM = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               clr_lsr,
    input  logic               clr_msr,
    input  logic               rx_ready,
    input  logic               thr_empty,
    input  logic               tx_empty,
    input  logic               ev_ovr,
    input  logic               ev_par,
    input  logic               ev_frm,
    input  logic               ev_brk,
    input  logic [N_MODEM-1:0] modem_in,
    output logic [HR_DW-1:0]   lsr,
    output logic [HR_DW-1:0]   msr
);
    logic [3:0]         err_q;
    logic               derr_q;
    logic [3:0]         ev_vec;
    logic [N_MODEM-1:0] prev_q;
    logic [N_MODEM-1:0] delta_q;
    logic [N_MODEM-1:0] chg;

    assign ev_vec = {ev_brk, ev_frm, ev_par, ev_ovr};

    // Latch line errors; a read clears them unless a new event lands.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            err_q  <= '0;
            derr_q <= 1'b0;
        end else begin
            err_q  <= (clr_lsr ? 4'b0 : err_q) | ev_vec;
            derr_q <= (clr_lsr ? 1'b0 : derr_q) | ev_brk | ev_frm | ev_par;
        end
    end

    // Per-line change detect; the ring line reports only its falling edge.
    for (genvar i = 0; i < N_MODEM; i++) begin : g_chg
        if (i == RI_BIT) begin : g_trail
            assign chg[i] = prev_q[i] & ~modem_in[i];
        end else begin : g_any
            assign chg[i] = prev_q[i] ^ modem_in[i];
        end
    end

    // Track modem lines and latch their deltas until read.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prev_q  <= modem_in;
            delta_q <= '0;
        end else begin
            prev_q  <= modem_in;
            delta_q <= (clr_msr ? '0 : delta_q) | chg;
        end
    end

    assign lsr = {derr_q, tx_empty, thr_empty, err_q, rx_ready};
    assign msr = {modem_in, delta_q};

    // R9: an overrun pulse is visible in the next cycle whatever else happens.
    p_ovr_kept_r9: assert property (@(posedge clk) disable iff (!rst_n)
        ev_ovr |=> lsr[1]);

    // R9: a status read with no new event leaves the error bits clear.
    p_lsr_cleared_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_lsr && !ev_ovr && !ev_par && !ev_frm && !ev_brk) |=>
            (lsr[4:1] == 4'b0 && !lsr[7]));

    // R10: a ring line falling edge is reported.
    p_ri_trail_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(modem_in[RI_BIT]) |-> ##1 msr[RI_BIT]);

    // R10: deltas are gone after a read with steady lines.
    p_msr_cleared_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_msr && $stable(modem_in)) |=> (msr[N_MODEM-1:0] == '0) || $changed(modem_in));
endmodule

// File: rtl/uart_hostregs.sv
// Top of the UART host register bank: decodes host accesses by page
// state, raises access strobes, masks the extended fields and muxes reads.
// Assumes wr_en and rd_en are not high in the same cycle.
module uart_hostregs
    import uart_hostregs_pkg::*;
(
    input  logic         clk,
    input  logic         rst_n,
    input  logic [2:0]   addr,
    input  logic         wr_en,
    input  logic         rd_en,
    input  logic [7:0]   wdata,
    output logic [7:0]   rdata,
    output logic         tx_load,
    output logic         rx_pop,
    output logic         fcr_wr,
    output logic         idx_wr,
    output logic [7:0]   idx_addr,
    input  logic [7:0]   rx_data,
    input  logic [7:0]   isr_in,
    input  logic [7:0]   idx_rdata,
    input  logic         rx_ready,
    input  logic         thr_empty,
    input  logic         tx_empty,
    input  logic         ev_ovr,
    input  logic         ev_par,
    input  logic         ev_frm,
    input  logic         ev_brk,
    input  logic [3:0]   modem_in,
    output logic [15:0]  divisor,
    output logic [6:0]   lcr_fmt,
    output logic [7:0]   ier_mask,
    output logic [7:0]   mcr_out
);
    hr_sel_t          sel;
    logic             dlab;
    logic             enh;
    logic [HR_DW-1:0] ier_q;
    logic [HR_DW-1:0] mcr_q;
    logic [HR_DW-1:0] acr_q;
    logic [HR_DW-1:0] spr_q;
    logic [HR_DW-1:0] lsr;
    logic [HR_DW-1:0] msr;

    hr_decode u_decode (
        .addr   (addr),
        .dlab   (dlab),
        .enh    (enh),
        .icr_on (acr_q[6]),
        .sel    (sel)
    );

    hr_ctrl u_ctrl (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wdata   (wdata),
        .sel_lcr (sel.lcr),
        .sel_dll (sel.dll),
        .sel_dlm (sel.dlm),
        .sel_ier (sel.ier),
        .sel_mcr (sel.mcr),
        .sel_acr (sel.acr),
        .sel_spr (sel.spr),
        .dlab    (dlab),
        .enh     (enh),
        .lcr_fmt (lcr_fmt),
        .divisor (divisor),
        .ier_q   (ier_q),
        .mcr_q   (mcr_q),
        .acr_q   (acr_q),
        .spr_q   (spr_q)
    );

    hr_status #(.N_MODEM(4)) u_status (
        .clk       (clk),
        .rst_n     (rst_n),
        .clr_lsr   (rd_en && sel.lsr),
        .clr_msr   (rd_en && sel.msr),
        .rx_ready  (rx_ready),
        .thr_empty (thr_empty),
        .tx_empty  (tx_empty),
        .ev_ovr    (ev_ovr),
        .ev_par    (ev_par),
        .ev_frm    (ev_frm),
        .ev_brk    (ev_brk),
        .modem_in  (modem_in),
        .lsr       (lsr),
        .msr       (msr)
    );

    // Access strobes toward the core.
    assign tx_load  = wr_en && sel.data;
    assign rx_pop   = rd_en && sel.data;
    assign fcr_wr   = wr_en && sel.fifo;
    assign idx_wr   = wr_en && sel.idx;
    assign idx_addr = spr_q;

    // Extended fields are hidden while the extended enable is off.
    assign ier_mask = acr_q[7] ? ier_q : (ier_q & IER_BASE_MASK);
    assign mcr_out  = acr_q[7] ? mcr_q : (mcr_q & MCR_BASE_MASK);

    // Read mux: the selected register, zero when idle or unimplemented.
    always_comb begin
        rdata = '0;
        if (rd_en) begin
            if (sel.data) rdata = rx_data;
            if (sel.dll)  rdata = divisor[7:0];
            if (sel.dlm)  rdata = divisor[15:8];
            if (sel.ier)  rdata = ier_mask;
            if (sel.fifo) rdata = isr_in;
            if (sel.acr)  rdata = acr_q;
            if (sel.lcr)  rdata = {dlab, lcr_fmt};
            if (sel.mcr)  rdata = mcr_out;
            if (sel.lsr)  rdata = lsr;
            if (sel.idx)  rdata = idx_rdata;
            if (sel.msr)  rdata = msr;
            if (sel.spr)  rdata = spr_q;
        end
    end

    // R1: a data read with divisor access off hands over the receive byte.
    p_rhr_read_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && addr == 3'd0 && !dlab) |-> (rx_pop && rdata == rx_data));

    // R13: the upper offsets are silent while the enhanced page is open.
    p_enh_silent_r13: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && enh && addr[2]) |-> (rdata == 8'h00));

    // R7: extended fields stay dark while the extended enable is off.
    p_ext_gate_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !acr_q[7] |-> (ier_mask[7:4] == 4'h0 && mcr_out[7:5] == 3'h0));

    // R2: divisor access never pulses the data path strobes.
    p_no_strobe_dlab_r2: assert property (@(posedge clk) disable iff (!rst_n)
        dlab |-> (!tx_load && !rx_pop));
endmodule

// File: tb/uart_hostregs_tb_top.sv
`timescale 1ns/1ps
module uart_hostregs_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [2:0]  addr = '0;
    logic        wr_en = 1'b0;
    logic        rd_en = 1'b0;
    logic [7:0]  wdata = '0;
    logic [7:0]  rdata;
    logic        tx_load, rx_pop, fcr_wr, idx_wr;
    logic [7:0]  idx_addr;
    logic [7:0]  rx_data = '0;
    logic [7:0]  isr_in = '0;
    logic [7:0]  idx_rdata = '0;
    logic        rx_ready = 1'b0, thr_empty = 1'b0, tx_empty = 1'b0;
    logic        ev_ovr = 1'b0, ev_par = 1'b0, ev_frm = 1'b0, ev_brk = 1'b0;
    logic [3:0]  modem_in = '0;
    logic [15:0] divisor;
    logic [6:0]  lcr_fmt;
    logic [7:0]  ier_mask, mcr_out;

    int    n_checks = 0;
    int    n_fails = 0;
    string cur_req = "R12";

    always #10 clk = ~clk;

    uart_hostregs dut_i (
        .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en), .rd_en(rd_en),
        .wdata(wdata), .rdata(rdata), .tx_load(tx_load), .rx_pop(rx_pop),
        .fcr_wr(fcr_wr), .idx_wr(idx_wr), .idx_addr(idx_addr),
        .rx_data(rx_data), .isr_in(isr_in), .idx_rdata(idx_rdata),
        .rx_ready(rx_ready), .thr_empty(thr_empty), .tx_empty(tx_empty),
        .ev_ovr(ev_ovr), .ev_par(ev_par), .ev_frm(ev_frm), .ev_brk(ev_brk),
        .modem_in(modem_in), .divisor(divisor), .lcr_fmt(lcr_fmt),
        .ier_mask(ier_mask), .mcr_out(mcr_out)
    );

    // Behavioural model state, written from the requirements.
    bit [6:0] m_fmt;
    bit       m_div_on, m_page;
    bit [7:0] m_lo, m_hi, m_mask, m_modem, m_add, m_scr;
    bit       m_ovr, m_par, m_frm, m_brk, m_err;
    bit [3:0] m_dl, m_last;

    function automatic bit [7:0] m_stat_line();
        return {m_err, tx_empty, thr_empty, m_brk, m_frm, m_par, m_ovr, rx_ready};
    endfunction

    function automatic bit [7:0] m_read();
        if (!rd_en) return 8'h00;
        case (int'(addr))
            0: return m_div_on ? m_lo : rx_data;
            1: return m_div_on ? m_hi : (m_add[7] ? m_mask : (m_mask & 8'h0F));
            2: return m_page ? m_add : isr_in;
            3: return {m_div_on, m_fmt};
            4: return m_page ? 8'h00 : (m_add[7] ? m_modem : (m_modem & 8'h1F));
            5: return m_page ? 8'h00 : (m_add[6] ? idx_rdata : m_stat_line());
            6: return m_page ? 8'h00 : {modem_in, m_dl};
            default: return m_page ? 8'h00 : m_scr;
        endcase
    endfunction

    // Model step on each rising edge.
    always @(posedge clk) begin
        bit clr_l, clr_m;
        bit [3:0] edges;
        if (!rst_n) begin
            m_fmt = 0; m_div_on = 0; m_page = 0;
            m_lo = 0; m_hi = 0; m_mask = 0; m_modem = 0; m_add = 0; m_scr = 0;
            m_ovr = 0; m_par = 0; m_frm = 0; m_brk = 0; m_err = 0;
            m_dl = 0; m_last = modem_in;
        end else begin
            clr_l = rd_en && addr == 3'd5 && !m_page && !m_add[6];
            clr_m = rd_en && addr == 3'd6 && !m_page;
            for (int i = 0; i < 4; i++)
                edges[i] = (i == 2) ? (m_last[i] && !modem_in[i]) : (m_last[i] != modem_in[i]);
            if (clr_l) begin m_ovr = 0; m_par = 0; m_frm = 0; m_brk = 0; m_err = 0; end
            m_ovr |= ev_ovr; m_par |= ev_par; m_frm |= ev_frm; m_brk |= ev_brk;
            m_err |= ev_par | ev_frm | ev_brk;
            if (clr_m) m_dl = 0;
            m_dl |= edges;
            m_last = modem_in;
            if (wr_en) begin
                case (int'(addr))
                    0: if (m_div_on) m_lo = wdata;
                    1: if (m_div_on) m_hi = wdata;
                       else m_mask = m_add[7] ? wdata : (wdata & 8'h0F);
                    2: if (m_page) m_add = wdata;
                    3: if (wdata == 8'hBF) begin m_page = 1; m_div_on = 1; end
                       else begin m_page = 0; m_div_on = wdata[7]; m_fmt = wdata[6:0]; end
                    4: if (!m_page) m_modem = m_add[7] ? wdata : (wdata & 8'h1F);
                    7: if (!m_page) m_scr = wdata;
                    default: ;
                endcase
            end
        end
    end

    // Compare every DUT output against the model.
    task automatic compare_all();
        logic [58:0] act, exp;
        act = {rdata, tx_load, rx_pop, fcr_wr, idx_wr, idx_addr, divisor, lcr_fmt, ier_mask, mcr_out};
        exp = {m_read(),
               wr_en && addr == 3'd0 && !m_div_on,
               rd_en && addr == 3'd0 && !m_div_on,
               wr_en && addr == 3'd2 && !m_page,
               wr_en && addr == 3'd5 && !m_page && m_add[6],
               m_scr, m_hi, m_lo, m_fmt,
               (m_add[7] ? m_mask : (m_mask & 8'h0F)),
               (m_add[7] ? m_modem : (m_modem & 8'h1F))};
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s cycle compare: actual %h expected %h", cur_req, act, exp);
        end
    endtask

    task automatic step(input int kind, input logic [2:0] a, input logic [7:0] d);
        wr_en = (kind == 1); rd_en = (kind == 2); addr = a; wdata = d;
        #1 compare_all();
        @(negedge clk);
        wr_en = 0; rd_en = 0;
        ev_ovr = 0; ev_par = 0; ev_frm = 0; ev_brk = 0;
    endtask

    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        step(1, a, d);
    endtask

    task automatic idle();
        step(0, 3'd0, 8'h00);
    endtask

    // Read with an explicit expected value as well as the model compare.
    task automatic rd(input logic [2:0] a, input logic [7:0] e);
        wr_en = 0; rd_en = 1; addr = a; wdata = 8'h00;
        #1 compare_all();
        n_checks++;
        if (rdata !== e) begin
            n_fails++;
            $display("FAIL %s read offset %0d: actual %h expected %h", cur_req, a, rdata, e);
        end
        @(negedge clk);
        rd_en = 0;
        ev_ovr = 0; ev_par = 0; ev_frm = 0; ev_brk = 0;
    endtask

    initial begin
        #(20 * 150000);
        n_fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fails);
        $finish;
    end

    initial begin
        logic [31:0] lf;
        @(negedge clk);
        cur_req = "R12";
        idle(); idle();
        rst_n = 1'b1;
        idle();
        rd(3'd3, 8'h00);

        cur_req = "R1";
        wr(3'd0, 8'h3C);
        rx_data = 8'hA5;
        rd(3'd0, 8'hA5);

        cur_req = "R6";
        wr(3'd3, 8'h5B);
        rd(3'd3, 8'h5B);

        cur_req = "R2";
        wr(3'd3, 8'h83);
        wr(3'd0, 8'h34);
        wr(3'd1, 8'h12);
        rd(3'd0, 8'h34);
        rd(3'd1, 8'h12);
        wr(3'd3, 8'h03);
        wr(3'd1, 8'h0A);
        rd(3'd1, 8'h0A);
        rd(3'd0, 8'hA5);

        cur_req = "R4";
        wr(3'd3, 8'hBF);
        rd(3'd3, 8'h83);
        rd(3'd0, 8'h34);

        cur_req = "R7";
        wr(3'd2, 8'h80);
        rd(3'd2, 8'h80);

        cur_req = "R13";
        wr(3'd4, 8'hFF);
        rd(3'd4, 8'h00);
        wr(3'd7, 8'hAA);
        rd(3'd7, 8'h00);
        ev_ovr = 1; idle();
        rd(3'd5, 8'h00);
        rd(3'd6, 8'h00);

        cur_req = "R5";
        wr(3'd3, 8'h1B);
        rd(3'd3, 8'h1B);
        rd(3'd0, 8'hA5);
        rd(3'd7, 8'h00);

        cur_req = "R7";
        wr(3'd4, 8'hFF);
        rd(3'd4, 8'hFF);
        wr(3'd1, 8'hF3);
        rd(3'd1, 8'hF3);
        wr(3'd3, 8'hBF);
        wr(3'd2, 8'h00);
        wr(3'd3, 8'h03);
        rd(3'd4, 8'h1F);
        rd(3'd1, 8'h03);

        cur_req = "R3";
        wr(3'd2, 8'hC1);
        isr_in = 8'hC2;
        rd(3'd2, 8'hC2);

        cur_req = "R11";
        wr(3'd7, 8'h5E);
        rd(3'd7, 8'h5E);

        cur_req = "R9";
        rd(3'd5, 8'h02);
        rx_ready = 1; thr_empty = 1; tx_empty = 1;
        ev_ovr = 1; idle();
        ev_frm = 1; idle();
        rd(3'd5, 8'hEB);
        rd(3'd5, 8'h61);
        ev_par = 1; rd(3'd5, 8'h61);
        rd(3'd5, 8'hE5);
        rd(3'd5, 8'h61);

        cur_req = "R10";
        modem_in = 4'b0100; idle();
        rd(3'd6, 8'h40);
        modem_in = 4'b0000; idle();
        rd(3'd6, 8'h04);
        modem_in = 4'b1011; idle();
        rd(3'd6, 8'hBB);
        rd(3'd6, 8'hB0);

        cur_req = "R8";
        wr(3'd3, 8'hBF);
        wr(3'd2, 8'h40);
        wr(3'd3, 8'h03);
        wr(3'd7, 8'h21);
        idx_rdata = 8'h77;
        wr(3'd5, 8'h9C);
        rd(3'd5, 8'h77);
        ev_ovr = 1; idle();
        rd(3'd5, 8'h77);
        wr(3'd3, 8'hBF);
        wr(3'd2, 8'h00);
        wr(3'd3, 8'h03);
        rd(3'd5, 8'h63);

        cur_req = "R9 mixed";
        lf = 32'h1234_5678;
        for (int n = 0; n < 600; n++) begin
            lf = {lf[30:0], lf[31] ^ lf[21] ^ lf[1] ^ lf[0]};
            rx_data   = lf[15:8];
            isr_in    = lf[23:16];
            idx_rdata = lf[31:24];
            rx_ready  = lf[3];
            thr_empty = lf[7];
            tx_empty  = lf[11];
            ev_ovr = lf[21] & lf[25];
            ev_par = lf[22] & lf[26];
            ev_frm = lf[23] & lf[27];
            ev_brk = lf[24] & lf[19];
            if (lf[27] && lf[13]) modem_in = lf[31:28];
            step((lf[1:0] == 2'd1) ? 1 : ((lf[1:0] == 2'd2) ? 2 : 0),
                 lf[4:2],
                 (lf[20:17] == 4'd0) ? 8'hBF : lf[12:5]);
        end

        $display("[TB] %0d tests run, %0d failed", n_checks, n_fails);
        $finish;
    end
endmodule